// File: doc/BRIEF.md
# Serial Configuration Slave for a Dual-Channel Sensor Front End

This block is the digital control port of a two-sensor signal-conditioning front end. A host writes 8-bit command words over a four-wire SPI link (active-low select, clock idling low, data sampled on the falling clock edge, most significant bit first). The upper bits of each word pick one configuration field and the lower bits carry its new value. The fields are the sensor channel, the bandpass centre code, the gain code, the integrator time-constant code and the prescaler code. The block holds these fields and presents them as plain codes to the analog stages.

All SPI pins and the diagnostic pin are synchronised into the system clock. A word only takes effect when select is released after exactly eight falling clock edges. While a frame runs, the serial output returns the last word that was committed. The output-enable of the serial output follows a fixed order of precedence. The diagnostic pin wins first, then a disable bit in the prescaler field, then chip select.

The prescaler field also picks a division ratio for the system clock. The block turns that ratio into a one-cycle clock-enable pulse for the downstream switched-capacitor logic.

Top module: `spi_cfg_slave`

## Requirements
- R1: A word is shifted in MSB first, one bit per falling edge of `spi_sck` while `spi_cs_n` is low. Configuration outputs change only in response to the rising edge of `spi_cs_n`.
- R2: A frame is discarded, leaving every output unchanged, unless exactly 8 falling edges of `spi_sck` were seen between the fall and the rise of `spi_cs_n`.
- R3: A word of the form `00vvvvvv` loads `bpf_code` with v[5:0]. A word of the form `10vvvvvv` loads `gain_code` with v[5:0]. No other field changes.
- R4: A word `110vvvvv` loads `tc_code` with v[4:0]. A word `111xxxxs` loads `sensor_sel` with s (bit 0). No other field changes.
- R5: After reset every field is zero. This means channel 0, divide-by-one (`sc_clk_en` high every cycle) and the serial output enabled while selected.
- R6: With `diag_n` high and `spi_cs_n` high, `spi_miso_oe` is low.
- R7: A word `01xppppz` loads `presc_code` with word[4:0]. When z (bit 0 of `presc_code`) is 1, `spi_miso_oe` is low even while `spi_cs_n` is low.
- R8: While `diag_n` is low, `spi_miso_oe` is high whatever the state of `spi_cs_n` and the disable bit.
- R9: During a frame, `spi_miso` presents the last committed word MSB first. Bit 7 is valid before the first falling edge of `spi_sck`, and each later bit is valid before the following falling edge.
- R10: The divider code `presc_code[4:1]` maps 1..9 to ratios 4, 5, 6, 8, 10, 12, 16, 20 and 24. Codes 0 and 10..15 mean divide by 1. `sc_clk_en` is high for one cycle out of every ratio cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| diag_n | input | 1 | Diagnostic test pin, active low |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| sensor_sel | output | 1 | Selected sensor channel |
| bpf_code | output | 6 | Bandpass centre code |
| gain_code | output | 6 | Gain code |
| tc_code | output | 5 | Integrator time-constant code |
| presc_code | output | 5 | Prescaler divider code [4:1] and output-disable bit [0] |
| sc_clk_en | output | 1 | Divided clock enable for the switched-capacitor logic |

## Verification
The bench sends frames of seven and nine bits. A design that commits on a count of at least 8, or on the eighth edge, would corrupt a field, and the bench reports it. It checks that each frame returns the previously committed word rather than the word being received, and that a discarded frame does not replace that word. It drives the three sources of output-enable against one another to catch a wrong order of precedence. It measures the enable period at the smallest ratio, the largest ratio, a middle ratio and a reserved code, which exposes an off-by-one in the divider.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int WORD_W   = 8;
  localparam int BPF_W    = 6;
  localparam int GAIN_W   = 6;
  localparam int TC_W     = 5;
  localparam int PRESC_W  = 5;
  localparam int DIVSEL_W = PRESC_W - 1;
  localparam int DIV_W    = 5;
  localparam int CNT_W    = $clog2(WORD_W + 2);

  typedef struct packed {
    logic                sensor;
    logic [BPF_W-1:0]    bpf;
    logic [GAIN_W-1:0]   gain;
    logic [TC_W-1:0]     tc;
    logic [PRESC_W-1:0]  presc;
  } cfg_t;

  typedef enum logic [2:0] {
    TGT_BPF,
    TGT_GAIN,
    TGT_TC,
    TGT_CHAN,
    TGT_PRESC
  } target_e;

  // Field chosen by the top bits of a command word.
  function automatic target_e decode_target(input logic [WORD_W-1:0] w);
    target_e t;
    unique casez (w[WORD_W-1 -: 3])
      3'b00?:  t = TGT_BPF;
      3'b01?:  t = TGT_PRESC;
      3'b10?:  t = TGT_GAIN;
      3'b110:  t = TGT_TC;
      default: t = TGT_CHAN;
    endcase
    return t;
  endfunction

  // Division ratio for each divider code; unlisted codes divide by one.
  function automatic logic [DIV_W-1:0] ratio_of(input logic [DIVSEL_W-1:0] c);
    logic [DIV_W-1:0] r;
    case (c)
      4'd1:    r = 5'd4;
      4'd2:    r = 5'd5;
      4'd3:    r = 5'd6;
      4'd4:    r = 5'd8;
      4'd5:    r = 5'd10;
      4'd6:    r = 5'd12;
      4'd7:    r = 5'd16;
      4'd8:    r = 5'd20;
      4'd9:    r = 5'd24;
      default: r = 5'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int               WIDTH  = 4,
  parameter int               STAGES = 2,
  parameter logic [WIDTH-1:0] RST_V  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] src;
      if (g == 0) begin : g_first
        assign src = d_in;
      end else begin : g_next
        assign src = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_V;
        else        stage_q[g] <= src;
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/spi_cfg_shifter.sv
module spi_cfg_shifter
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [WORD_W-1:0] echo_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              word_ok,
  output logic              frame_end,
  output logic              miso
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic              sck_q, cs_n_q;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sck_fall, frame_start, active;

  assign sck_fall    = sck_q & ~sck_s;
  assign frame_start = cs_n_q & ~cs_n_s;
  assign frame_end   = ~cs_n_q & cs_n_s;
  assign active      = ~cs_n_s;

  always_comb begin
    rx_d  = rx_q;
    tx_d  = tx_q;
    cnt_d = cnt_q;
    if (frame_start) begin
      cnt_d = '0;
      tx_d  = echo_word;
    end else if (active && sck_fall) begin
      rx_d  = {rx_q[WORD_W-2:0], mosi_s};
      tx_d  = {tx_q[WORD_W-2:0], 1'b0};
      cnt_d = (cnt_q == OVER) ? OVER : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_n_q <= 1'b1;
      rx_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sck_q  <= sck_s;
      cs_n_q <= cs_n_s;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rx_word = rx_q;
  assign word_ok = frame_end && (cnt_q == FULL);
  assign miso    = tx_q[WORD_W-1];

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output cfg_t              cfg,
  output logic [WORD_W-1:0] last_word
);

  cfg_t              cfg_q, cfg_d;
  logic [WORD_W-1:0] last_q, last_d;
  target_e           tgt;

  assign tgt = decode_target(word);

  always_comb begin
    cfg_d  = cfg_q;
    last_d = last_q;
    if (load) begin
      last_d = word;
      unique case (tgt)
        TGT_BPF:   cfg_d.bpf    = word[BPF_W-1:0];
        TGT_GAIN:  cfg_d.gain   = word[GAIN_W-1:0];
        TGT_TC:    cfg_d.tc     = word[TC_W-1:0];
        TGT_PRESC: cfg_d.presc  = word[PRESC_W-1:0];
        default:   cfg_d.sensor = word[0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      last_q <= '0;
    end else if (load) begin
      cfg_q  <= cfg_d;
      last_q <= last_d;
    end
  end

  assign cfg       = cfg_q;
  assign last_word = last_q;

endmodule

// File: rtl/spi_cfg_prescaler.sv
module spi_cfg_prescaler
  import spi_cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIVSEL_W-1:0] div_sel,
  output logic                clk_en
);

  logic [DIV_W-1:0] ratio;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign ratio  = ratio_of(div_sel);
  assign clk_en = (cnt_q >= ratio - 1'b1);

  always_comb begin
    cnt_d = clk_en ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_sck,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  input  logic               diag_n,
  output logic               spi_miso,
  output logic               spi_miso_oe,
  output logic               sensor_sel,
  output logic [BPF_W-1:0]   bpf_code,
  output logic [GAIN_W-1:0]  gain_code,
  output logic [TC_W-1:0]    tc_code,
  output logic [PRESC_W-1:0] presc_code,
  output logic               sc_clk_en
);

  localparam int SYNC_W = 4;

  logic [SYNC_W-1:0] pins_s;
  logic              sck_s, cs_n_s, mosi_s, diag_n_s;
  logic [WORD_W-1:0] rx_word, last_word;
  logic              word_ok, frame_end;
  cfg_t              cfg;

  spi_cfg_sync #(
    .WIDTH (SYNC_W),
    .STAGES(2),
    .RST_V (4'b1010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in ({diag_n, spi_sck, spi_cs_n, spi_mosi}),
    .d_out(pins_s)
  );

  assign {diag_n_s, sck_s, cs_n_s, mosi_s} = pins_s;

  spi_cfg_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sck_s),
    .cs_n_s   (cs_n_s),
    .mosi_s   (mosi_s),
    .echo_word(last_word),
    .rx_word  (rx_word),
    .word_ok  (word_ok),
    .frame_end(frame_end),
    .miso     (spi_miso)
  );

  spi_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (word_ok),
    .word     (rx_word),
    .cfg      (cfg),
    .last_word(last_word)
  );

  spi_cfg_prescaler u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_sel(cfg.presc[PRESC_W-1:1]),
    .clk_en (sc_clk_en)
  );

  // Precedence: diagnostic pin, then disable bit, then chip select.
  always_comb begin
    if (!diag_n_s)         spi_miso_oe = 1'b1;
    else if (cfg.presc[0]) spi_miso_oe = 1'b0;
    else                   spi_miso_oe = ~cs_n_s;
  end

  assign sensor_sel = cfg.sensor;
  assign bpf_code   = cfg.bpf;
  assign gain_code  = cfg.gain;
  assign tc_code    = cfg.tc;
  assign presc_code = cfg.presc;

endmodule

// File: rtl/spi_cfg_checker.sv
module spi_cfg_checker
  import spi_cfg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               spi_cs_n,
  input logic               diag_n,
  input logic               spi_miso_oe,
  input logic               sensor_sel,
  input logic [BPF_W-1:0]   bpf_code,
  input logic [GAIN_W-1:0]  gain_code,
  input logic [TC_W-1:0]    tc_code,
  input logic [PRESC_W-1:0] presc_code,
  input logic               sc_clk_en,
  input logic               frame_end
);

  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  assign warm = (age_q == 2'd3);

  // R1: configuration moves only right after a select release
  p_commit_on_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$stable({sensor_sel, bpf_code, gain_code, tc_code, presc_code}))
      |-> $past(frame_end));

  // R6: deselected and not in diagnostics means high impedance
  p_hiz_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(spi_cs_n, 2) && $past(diag_n, 2)) |-> !spi_miso_oe);

  // R7: disable bit forces high impedance outside diagnostics
  p_hiz_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && presc_code[0] && $past(diag_n, 2)) |-> !spi_miso_oe);

  // R8: diagnostic pin always drives the output
  p_diag_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(diag_n, 2)) |-> spi_miso_oe);

  // R10: divide-by-one codes keep the enable high
  p_div_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_code[4:1] == 4'd0 || presc_code[4:1] > 4'd9) |-> sc_clk_en);

  // R10: enable is a single-cycle pulse for ratios above one
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_clk_en && presc_code[4:1] != 4'd0 && presc_code[4:1] <= 4'd9)
      |=> (!sc_clk_en || !$stable(presc_code)));

endmodule

bind spi_cfg_slave spi_cfg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_cs_n   (spi_cs_n),
  .diag_n     (diag_n),
  .spi_miso_oe(spi_miso_oe),
  .sensor_sel (sensor_sel),
  .bpf_code   (bpf_code),
  .gain_code  (gain_code),
  .tc_code    (tc_code),
  .presc_code (presc_code),
  .sc_clk_en  (sc_clk_en),
  .frame_end  (frame_end)
);

// File: tb/sim_spi_cfg_slave.sv
module sim_spi_cfg_slave;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_mosi = 1'b0;
  logic       diag_n = 1'b1;
  logic       spi_miso, spi_miso_oe, sensor_sel, sc_clk_en;
  logic [5:0] bpf_code, gain_code;
  logic [4:0] tc_code, presc_code;

  int checks = 0;
  int fails = 0;
  logic [7:0] last_good = 8'h00;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_cfg_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .diag_n(diag_n), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .sensor_sel(sensor_sel), .bpf_code(bpf_code),
    .gain_code(gain_code), .tc_code(tc_code), .presc_code(presc_code),
    .sc_clk_en(sc_clk_en)
  );

  localparam int NV = 8;
  localparam logic [7:0] VW [NV] = '{8'h2D, 8'hB3, 8'hD6, 8'hE1,
                                     8'h48, 8'hE0, 8'h01, 8'hBF};
  // expected {sensor, bpf, gain, tc, presc}
  localparam logic [22:0] VE [NV] = '{
    {1'b0, 6'h2D, 6'h00, 5'h00, 5'h00},
    {1'b0, 6'h2D, 6'h33, 5'h00, 5'h00},
    {1'b0, 6'h2D, 6'h33, 5'h16, 5'h00},
    {1'b1, 6'h2D, 6'h33, 5'h16, 5'h00},
    {1'b1, 6'h2D, 6'h33, 5'h16, 5'h08},
    {1'b0, 6'h2D, 6'h33, 5'h16, 5'h08},
    {1'b0, 6'h01, 6'h33, 5'h16, 5'h08},
    {1'b0, 6'h01, 6'h3F, 5'h16, 5'h08}};

  function automatic logic [22:0] cfg_now();
    return {sensor_sel, bpf_code, gain_code, tc_code, presc_code};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nbits of w MSB first; returns the bits seen on miso before each fall.
  task automatic send(input logic [7:0] w, input int nbits, output logic [7:0] echo);
    echo = '0;
    spi_cs_n = 1'b0;
    idle(8);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 8) ? w[7-i] : 1'b0;
      idle(2);
      spi_sck = 1'b1;
      idle(8);
      if (i < 8) echo[7-i] = spi_miso;
      spi_sck = 1'b0;
      idle(8);
    end
    idle(4);
    spi_cs_n = 1'b1;
    idle(10);
  endtask

  task automatic measure(output int period);
    int t = 0;
    while (sc_clk_en !== 1'b1 && t < 100) begin idle(1); t++; end
    idle(1);
    period = 1;
    while (sc_clk_en !== 1'b1 && period < 100) begin idle(1); period++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] echo;
    int per;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R5: reset values
    check("R5 fields", 32'(cfg_now()), 32'h0);
    check("R5 div1 enable", 32'(sc_clk_en), 32'h1);
    check("R6 oe deselected", 32'(spi_miso_oe), 32'h0);
    spi_cs_n = 1'b0;
    idle(5);
    check("R5 oe enabled when selected", 32'(spi_miso_oe), 32'h1);
    spi_cs_n = 1'b1;
    idle(5);

    // R1/R3/R4/R7/R9: vector table
    for (int k = 0; k < NV; k++) begin
      send(VW[k], 8, echo);
      check("R9 echo of previous word", 32'(echo), 32'(last_good));
      check("R1 R3 R4 R7 fields after commit", 32'(cfg_now()), 32'(VE[k]));
      last_good = VW[k];
    end

    // R2: short and long frames are discarded
    send(8'h3F, 7, echo);
    check("R2 seven-bit frame ignored", 32'(cfg_now()), 32'(VE[NV-1]));
    send(8'hC7, 9, echo);
    check("R2 nine-bit frame ignored", 32'(cfg_now()), 32'(VE[NV-1]));
    send(8'hE1, 8, echo);
    check("R9 echo unchanged by discarded frames", 32'(echo), 32'(last_good));
    last_good = 8'hE1;

    // R10: divider ratios (code 4 currently set -> 8)
    measure(per);
    check("R10 ratio code4", 32'(per), 32'd8);
    send(8'h42, 8, echo); last_good = 8'h42;
    measure(per);
    check("R10 ratio code1", 32'(per), 32'd4);
    send(8'h52, 8, echo); last_good = 8'h52;
    measure(per);
    check("R10 ratio code9", 32'(per), 32'd24);
    send(8'h58, 8, echo); last_good = 8'h58;
    measure(per);
    check("R10 reserved code12", 32'(per), 32'd1);

    // R7: disable bit overrides chip select
    send(8'h41, 8, echo); last_good = 8'h41;
    check("R7 presc field", 32'(presc_code), 32'h01);
    spi_cs_n = 1'b0;
    idle(5);
    check("R7 hiz while selected", 32'(spi_miso_oe), 32'h0);
    // R8: diagnostic overrides disable bit and select
    diag_n = 1'b0;
    idle(5);
    check("R8 diag with disable bit", 32'(spi_miso_oe), 32'h1);
    spi_cs_n = 1'b1;
    idle(5);
    check("R8 diag while deselected", 32'(spi_miso_oe), 32'h1);
    diag_n = 1'b1;
    idle(5);
    check("R6 deselected after diag", 32'(spi_miso_oe), 32'h0);
    send(8'h40, 8, echo);
    check("R9 echo of disable word", 32'(echo), 32'h41);
    spi_cs_n = 1'b0;
    idle(5);
    check("R7 enabled when bit clear", 32'(spi_miso_oe), 32'h1);
    spi_cs_n = 1'b1;
    idle(5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule